// File: doc/BRIEF.md
# Ultrasonic Echo Ranging Controller

This block runs a trigger-and-echo ultrasonic distance sensor on its own. On a fixed repetition period it drives a trigger pulse of fixed width, then watches the echo line. The sensor holds echo high for the round-trip flight time of the sound burst. The block times that high interval in whole microseconds and converts it to a distance in millimetres.

Each finished measurement loads a new distance and raises a one-cycle valid strobe. Results outside the usable window are clamped to the nearest bound and flagged. If the echo never rises, or stays high far longer than the farthest usable target would need, the block raises a timeout flag instead and keeps the last good distance. The echo input is asynchronous and is synchronised inside the block.

Top module: `sonar_ranger`

## Requirements
- R1: Every measurement drives `trig_out` high for exactly TRIG_US × CLK_PER_US consecutive clock cycles.
- R2: Successive rising edges of `trig_out` are exactly PERIOD_CYC clock cycles apart.
- R3: An echo held high for between t·CLK_PER_US+1 and t·CLK_PER_US+CLK_PER_US cycles measures as t microseconds, and the loaded distance is floor(t × 11239 / 65536) millimetres (343/2000 in 16-bit fixed point).
- R4: A computed distance below MIN_MM loads MIN_MM, and one above MAX_MM loads MAX_MM. Either case sets `range_flag` to 1. An in-range result clears `range_flag` to 0.
- R5: If echo does not rise within RISE_MAX_US microseconds after the trigger ends, `timeout` goes to 1, no valid strobe is produced, and `dist_mm` keeps its previous value.
- R6: If echo stays high for ECHO_MAX_US microseconds, `timeout` goes to 1, no valid strobe is produced, and `dist_mm` keeps its previous value.
- R7: Each successful measurement pulses `dist_valid` high for exactly one cycle, in the same cycle that the new distance appears. That pulse also clears `timeout` to 0.
- R8: While reset is asserted, `trig_out`, `dist_mm`, `dist_valid`, `timeout` and `range_flag` are all 0. Reset is asynchronous, so these outputs clear at once even in the middle of a measurement.
- R9: Echo pulses that arrive between measurements, outside the echo wait window, produce no valid strobe and leave `dist_mm` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| echo_in | input | 1 | Raw echo line from the sensor |
| trig_out | output | 1 | Trigger pulse to the sensor |
| dist_mm | output | DIST_W | Last measured distance in millimetres |
| dist_valid | output | 1 | One-cycle strobe when a new distance is loaded |
| timeout | output | 1 | Last measurement failed; held until the next good one |
| range_flag | output | 1 | Last loaded distance was clamped to a bound |

## Verification
The bench targets the clamping edges. It uses echo times one microsecond either side of the lower and upper distance bounds, plus zero-length and one-microsecond echoes. An off-by-one in the comparison or in the microsecond count would load the wrong distance or set the wrong flag. Both timeout paths are tested. A design that loaded a distance on a failed measurement, or that produced a valid strobe anyway, would show a changed `dist_mm` or an extra strobe. Stray echo pulses between measurements are also sent; a design that responded to them would produce a strobe. The trigger width and trigger spacing are measured on every measurement, and a reset is applied while a trigger is in progress.

// File: rtl/sonar_ranger.sv
module sonar_ranger #(
  parameter int CLK_PER_US  = 200,
  parameter int TRIG_US     = 10,
  parameter int PERIOD_CYC  = 12_000_000,
  parameter int RISE_MAX_US = 1000,
  parameter int ECHO_MAX_US = 25000,
  parameter int MIN_MM      = 20,
  parameter int MAX_MM      = 4000,
  parameter int DIST_W      = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              echo_in,
  output logic              trig_out,
  output logic [DIST_W-1:0] dist_mm,
  output logic              dist_valid,
  output logic              timeout,
  output logic              range_flag
);

  localparam int LIM_US   = (RISE_MAX_US > ECHO_MAX_US) ? RISE_MAX_US : ECHO_MAX_US;
  localparam int US_W     = $clog2(LIM_US + 1);
  localparam int PRE_W    = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam int PER_W    = $clog2(PERIOD_CYC);
  localparam int TRIG_CYC = TRIG_US * CLK_PER_US;
  localparam int TW       = $clog2(TRIG_CYC + 2);
  localparam int SCALE    = 11239;
  localparam logic [US_W-1:0] TRIG_END = US_W'(TRIG_US - 1);
  localparam logic [US_W-1:0] RISE_LIM = US_W'(RISE_MAX_US);
  localparam logic [US_W-1:0] ECHO_LIM = US_W'(ECHO_MAX_US);
  localparam logic [US_W-1:0] MIN_V    = US_W'(MIN_MM);
  localparam logic [US_W-1:0] MAX_V    = US_W'(MAX_MM);

  typedef enum logic [2:0] {IDLE, TRIG, WAIT_RISE, MEASURE, DONE} state_t;

  state_t           state;
  logic [2:0]       esh;
  logic [PRE_W-1:0] pre;
  logic [US_W-1:0]  us;
  logic [PER_W-1:0] per_cnt;
  logic [US_W+15:0] prod;
  logic [US_W-1:0]  raw;
  logic             rise, fall, tick, start, too_lo, too_hi;

  assign rise     = esh[1] & ~esh[2];
  assign fall     = ~esh[1] & esh[2];
  assign tick     = (pre == PRE_W'(CLK_PER_US - 1));
  assign start    = (per_cnt == PER_W'(PERIOD_CYC - 1));
  assign trig_out = (state == TRIG);
  assign prod     = (US_W+16)'(us) * (US_W+16)'(SCALE);
  assign raw      = prod[US_W+15:16];
  assign too_lo   = (raw < MIN_V);
  assign too_hi   = (raw > MAX_V);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= IDLE;
      esh        <= '0;
      pre        <= '0;
      us         <= '0;
      per_cnt    <= '0;
      dist_mm    <= '0;
      dist_valid <= 1'b0;
      timeout    <= 1'b0;
      range_flag <= 1'b0;
    end else begin
      esh        <= {esh[1:0], echo_in};
      per_cnt    <= start ? '0 : per_cnt + PER_W'(1);
      dist_valid <= 1'b0;
      pre        <= tick ? '0 : pre + PRE_W'(1);
      if (tick) us <= us + US_W'(1);
      case (state)
        IDLE: if (start) begin
          state <= TRIG;
          pre   <= '0;
          us    <= '0;
        end
        TRIG: if (tick && us == TRIG_END) begin
          state <= WAIT_RISE;
          pre   <= '0;
          us    <= '0;
        end
        WAIT_RISE: if (rise) begin
          state <= MEASURE;
          pre   <= '0;
          us    <= '0;
        end else if (us == RISE_LIM) begin
          timeout <= 1'b1;
          state   <= IDLE;
        end
        MEASURE: if (fall) begin
          state <= DONE;
          pre   <= pre;
          us    <= us;
        end else if (us == ECHO_LIM) begin
          timeout <= 1'b1;
          state   <= IDLE;
        end
        DONE: begin
          dist_mm    <= DIST_W'(too_lo ? MIN_V : (too_hi ? MAX_V : raw));
          range_flag <= too_lo | too_hi;
          dist_valid <= 1'b1;
          timeout    <= 1'b0;
          state      <= IDLE;
        end
        default: state <= IDLE;
      endcase
    end
  end

  logic [TW-1:0] trig_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig_run <= '0;
    else        trig_run <= trig_out ? trig_run + TW'(1) : '0;
  end

  assert_trig_width_R1: assert property (@(posedge clk) disable iff (!rst_n)
    trig_out |-> (trig_run < TW'(TRIG_CYC)));
  assert_trig_full_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(trig_out) |-> (trig_run == TW'(TRIG_CYC)));
  assert_dist_bounds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dist_valid |-> (dist_mm >= DIST_W'(MIN_MM) && dist_mm <= DIST_W'(MAX_MM)));
  assert_hold_on_timeout_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout) |-> ($stable(dist_mm) && !dist_valid));
  assert_valid_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dist_valid |=> !dist_valid);
  assert_valid_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dist_valid |-> !timeout);

endmodule

// File: tb/sonar_ranger_tb_top.sv
`timescale 1ns/1ps
module sonar_ranger_tb_top;
  localparam int C    = 4;
  localparam int TUS  = 10;
  localparam int PER  = 2000;
  localparam int RMAX = 50;
  localparam int EMAX = 300;
  localparam int MINM = 20;
  localparam int MAXM = 40;
  localparam int DW   = 12;
  localparam int NV   = 10;
  localparam int VUS  [NV] = '{150, 117, 116, 233, 234, 240, 200, 1, 0, 130};
  localparam int VDLY [NV] = '{3, 10, 1, 25, 7, 4, 15, 2, 9, 30};

  logic clk = 1'b0, rst_n = 1'b0, echo = 1'b0;
  logic trig_out, dist_valid, timeout, range_flag;
  logic [DW-1:0] dist_mm;

  sonar_ranger #(.CLK_PER_US(C), .TRIG_US(TUS), .PERIOD_CYC(PER), .RISE_MAX_US(RMAX),
    .ECHO_MAX_US(EMAX), .MIN_MM(MINM), .MAX_MM(MAXM), .DIST_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .echo_in(echo), .trig_out(trig_out), .dist_mm(dist_mm),
    .dist_valid(dist_valid), .timeout(timeout), .range_flag(range_flag));

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0, vcount = 0, cyc = 0, trun = 0, tw = 0, last_rise = -1, per = 0;
  logic tprev = 1'b0;

  always @(posedge clk) begin
    cyc++;
    if (dist_valid) vcount++;
    if (trig_out) trun++;
    else if (trun != 0) begin tw = trun; trun = 0; end
    if (trig_out && !tprev) begin
      if (last_rise >= 0) per = cyc - last_rise;
      last_rise = cyc;
    end
    tprev = trig_out;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_mm(input int t);
    int r = (t * 11239) >>> 16;
    if (r < MINM) return MINM;
    if (r > MAXM) return MAXM;
    return r;
  endfunction

  function automatic int exp_rng(input int t);
    int r = (t * 11239) >>> 16;
    return (r < MINM || r > MAXM) ? 1 : 0;
  endfunction

  // mode 0: normal echo of t us, 1: no echo, 2: echo stuck high
  task automatic meas(input int dly, input int t, input int mode);
    int v0, d0;
    @(posedge trig_out);
    v0 = vcount;
    d0 = int'(dist_mm);
    @(negedge trig_out);
    repeat (dly) @(negedge clk);
    if (mode == 0) begin
      echo = 1'b1;
      repeat (t * C + 2) @(negedge clk);
      echo = 1'b0;
      repeat (20) @(negedge clk);
      chk(vcount - v0 == 1, "R7 one valid strobe", vcount - v0, 1);
      chk(int'(dist_mm) == exp_mm(t), "R3/R4 distance", int'(dist_mm), exp_mm(t));
      chk(int'(range_flag) == exp_rng(t), "R4 range flag", int'(range_flag), exp_rng(t));
      chk(timeout == 1'b0, "R7 timeout clear", int'(timeout), 0);
    end else begin
      if (mode == 2) begin
        echo = 1'b1;
        repeat (EMAX * C + 100) @(negedge clk);
        echo = 1'b0;
        repeat (20) @(negedge clk);
      end else begin
        repeat (RMAX * C + 20) @(negedge clk);
      end
      chk(vcount == v0, (mode == 2) ? "R6 no strobe" : "R5 no strobe", vcount - v0, 0);
      chk(timeout == 1'b1, (mode == 2) ? "R6 timeout set" : "R5 timeout set", int'(timeout), 1);
      chk(int'(dist_mm) == d0, (mode == 2) ? "R6 distance held" : "R5 distance held",
          int'(dist_mm), d0);
    end
    chk(tw == TUS * C, "R1 trigger width", tw, TUS * C);
    if (per != 0) chk(per == PER, "R2 trigger period", per, PER);
  endtask

  initial begin
    #(5.0 * 200000);
    fails++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int v0, d0;
    repeat (5) @(negedge clk);
    chk(trig_out == 0 && dist_valid == 0 && timeout == 0 && range_flag == 0 && dist_mm == 0,
        "R8 reset state", int'(dist_mm), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(trig_out == 0 && dist_mm == 0, "R8 after release", int'(trig_out), 0);

    for (int i = 0; i < NV; i++) meas(VDLY[i], VUS[i], 0);

    meas(0, 0, 1);                 // R5 no echo
    meas(5, 150, 0);               // R7 good result clears timeout

    v0 = vcount; d0 = int'(dist_mm);   // R9 stray echo while idle
    echo = 1'b1;
    repeat (100) @(negedge clk);
    echo = 1'b0;
    repeat (20) @(negedge clk);
    chk(vcount == v0, "R9 idle echo no strobe", vcount - v0, 0);
    chk(int'(dist_mm) == d0, "R9 idle echo distance", int'(dist_mm), d0);

    meas(6, 0, 2);                 // R6 echo stuck high

    @(posedge trig_out);           // R8 reset mid-trigger
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(trig_out == 0 && dist_mm == 0 && timeout == 0 && range_flag == 0 && dist_valid == 0,
        "R8 async reset", int'(trig_out) + int'(timeout), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule